// File: doc/BRIEF.md
# SPI Interrupt Flag Register

This block holds the three status flags of an SPI serial port: receive complete, transmit complete and data register empty. It presents them as an 8-bit readable value and drives one interrupt request line. The SPI shift engine reports events to it as single-cycle pulses and as the level of slave-select. The bus side reports reads and writes of the data register, writes to the flag register and the receiver enable level. The block does not contain the shifter, the clock generator or the pin drivers.

Transmit complete is set differently in the two roles. In master mode it sets when a character has finished shifting out and no new data is waiting. In slave mode it sets when slave-select is released. When address matching is on, the slave-mode set happens only if the shift engine reported an address hit during that transaction. Each flag has its own set of clear events. When a flag has a set event and a clear event in the same cycle, the set wins, so no event is lost. The interrupt request is registered.

Top module: `spi_irq_flags`

## Requirements
- R1: After a synchronous active-low reset, all flag bits and `irq` are 0.
- R2: Bits 7 to 3 of `flags_q` always read 0, and flag-register writes to those bits change nothing.
- R3: Receive complete (bit 2) sets in the cycle after `char_rx` while `rx_enable` is high, and clears in the cycle after `data_rd`. Flag-register writes of 0 or 1 to bit 2 leave it unchanged.
- R4: While `rx_enable` is low, receive complete is 0 and `char_rx` cannot set it.
- R5: In master mode (`mode_master`=1), transmit complete (bit 1) sets on `shift_done` only when data register empty is 1 and `data_wr` is not asserted in the same cycle.
- R6: Transmit complete clears after a flag-register write with bit 1 = 1, or after `data_wr`. A flag-register write with bit 1 = 0 leaves it unchanged.
- R7: In slave mode, transmit complete sets in the cycle after `ss_n` goes from 0 to 1. When `addr_match_en` is 1, it sets only if `addr_hit` pulsed while `ss_n` was low in that transaction.
- R8: Data register empty (bit 0) becomes 1 in the cycle after `tx_load` and 0 in the cycle after `data_wr`. Flag-register writes do not affect it.
- R9: When a set event and a clear event for the same flag fall in the same cycle, the flag ends up 1.
- R10: `irq` is 1 in the cycle after any flag bit `k` (k = 0 data register empty, 1 transmit complete, 2 receive complete) is 1 together with `irq_en[k]`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_master | input | 1 | 1 = master role, 0 = slave role |
| addr_match_en | input | 1 | Address matching enabled |
| rx_enable | input | 1 | Receiver enable level |
| char_rx | input | 1 | Pulse: a character was placed in the receive buffer |
| shift_done | input | 1 | Pulse: a character finished shifting out (master) |
| ss_n | input | 1 | Slave-select level, active low |
| addr_hit | input | 1 | Pulse: the address character of this transaction matched |
| tx_load | input | 1 | Pulse: data register moved into the shifter |
| data_rd | input | 1 | Bus read strobe of the data register |
| data_wr | input | 1 | Bus write strobe of the data register |
| flag_wr | input | 1 | Bus write strobe of the flag register |
| flag_wdata | input | REG_W | Write data for the flag register |
| irq_en | input | NUM_FLAGS | Per-flag interrupt enable, indexed like the flag bits |
| flags_q | output | REG_W | Readable flag register value |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the same-cycle collisions: a receive with a data read, a load with a data write, a slave-select release with a write-one-to-clear, and a shift finishing while a data write arrives. A design with the wrong priority would drop a flag, or raise transmit complete while data is still waiting. It checks that the address-hit qualifier is forgotten at the end of each transaction. A design that kept it would raise transmit complete in a later, unmatched slave transaction. It also checks that flag-register writes of ones leave receive complete, data register empty and the reserved bits alone. A decoder that treated every bit as write-one-to-clear would fail those checks. It checks the one-cycle lag of `irq` behind the flags, which a combinational request would not meet.

// File: rtl/spi_flag_pkg.sv
// Package: shared widths, flag bit positions and role encoding for the
// SPI interrupt flag register. Assumes the three flags sit in the low bits.
package spi_flag_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 3;
    localparam int BIT_DRE   = 0;
    localparam int BIT_TXC   = 1;
    localparam int BIT_RXC   = 2;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } spi_role_e;
endpackage

// File: rtl/spi_rxc_flag.sv
// Module: receive-complete flag. Sets on a received character while the
// receiver is enabled and clears on a data read or while the receiver is
// off. A set beats a clear in the same cycle. Assumes single-cycle pulses.
module spi_rxc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_enable,
    input  logic char_rx,
    input  logic data_rd,
    output logic rxc_q
);
    logic set_ev;
    logic clr_ev;

    // Decode set and clear conditions for this cycle
    always_comb begin
        set_ev = char_rx & rx_enable;
        clr_ev = data_rd | ~rx_enable;
    end

    // Flag register, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      rxc_q <= 1'b0;
        else if (set_ev) rxc_q <= 1'b1;
        else if (clr_ev) rxc_q <= 1'b0;
    end
endmodule

// File: rtl/spi_dre_flag.sv
// Module: data-register-empty flag. Goes high the cycle after the shift
// engine takes the data register and low the cycle after a bus data write.
// A load beats a write in the same cycle. Resets low.
module spi_dre_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load,
    input  logic data_wr,
    output logic dre_q
);
    // Track whether the transmit data register is empty
    always_ff @(posedge clk) begin
        if (!rst_n)       dre_q <= 1'b0;
        else if (tx_load) dre_q <= 1'b1;
        else if (data_wr) dre_q <= 1'b0;
    end
endmodule

// File: rtl/spi_txc_flag.sv
// Module: transmit-complete flag. In the master role it sets when a
// character finishes with no data waiting. In the slave role it sets on
// the release of slave-select, optionally only when an address hit was
// seen in that transaction. Clears on a write-one or a data write; a set
// beats a clear. Assumes ss_n is already synchronous to clk.
module spi_txc_flag
    import spi_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  spi_role_e role,
    input  logic      addr_match_en,
    input  logic      shift_done,
    input  logic      ss_n,
    input  logic      addr_hit,
    input  logic      buf_empty,
    input  logic      data_wr,
    input  logic      clr_req,
    output logic      txc_q
);
    logic ss_prev;
    logic addr_ok;
    logic ss_rise;
    logic master_set;
    logic slave_set;
    logic set_ev;
    logic clr_ev;

    // Remember last slave-select level; idle high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) ss_prev <= 1'b1;
        else        ss_prev <= ss_n;
    end

    // Hold an address hit until the transaction ends
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_ok <= 1'b0;
        else if (ss_rise)           addr_ok <= 1'b0;
        else if (addr_hit && !ss_n) addr_ok <= 1'b1;
    end

    // Role-specific set decode and common clear decode
    always_comb begin
        ss_rise    = ss_n & ~ss_prev;
        master_set = (role == ROLE_MASTER) & shift_done & buf_empty & ~data_wr;
        slave_set  = (role == ROLE_SLAVE) & ss_rise & (~addr_match_en | addr_ok);
        set_ev     = master_set | slave_set;
        clr_ev     = clr_req | data_wr;
    end

    // Flag register, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      txc_q <= 1'b0;
        else if (set_ev) txc_q <= 1'b1;
        else if (clr_ev) txc_q <= 1'b0;
    end
endmodule

// File: rtl/spi_irq_combine.sv
// Module: gates each flag with its enable and registers the OR of the
// results into one interrupt request. Resets low.
module spi_irq_combine #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         irq_q
);
    logic [N-1:0] gated;

    // Per-flag enable gating
    for (genvar k = 0; k < N; k++) begin : g_gate
        assign gated[k] = flags[k] & en[k];
    end

    // Registered request so the output cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |gated;
    end
endmodule

// File: rtl/spi_irq_flags.sv
// Module: SPI interrupt flag register top. Collects the three flags into a
// REG_W-bit readable value with zero reserved bits and drives the
// registered interrupt request. Assumes all event inputs are synchronous,
// single-cycle pulses, and that REG_W is larger than NUM_FLAGS.
module spi_irq_flags
    import spi_flag_pkg::*;
#(
    parameter int REG_W_P     = REG_W,
    parameter int NUM_FLAGS_P = NUM_FLAGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_master,
    input  logic                   addr_match_en,
    input  logic                   rx_enable,
    input  logic                   char_rx,
    input  logic                   shift_done,
    input  logic                   ss_n,
    input  logic                   addr_hit,
    input  logic                   tx_load,
    input  logic                   data_rd,
    input  logic                   data_wr,
    input  logic                   flag_wr,
    input  logic [REG_W_P-1:0]     flag_wdata,
    input  logic [NUM_FLAGS_P-1:0] irq_en,
    output logic [REG_W_P-1:0]     flags_q,
    output logic                   irq
);
    localparam int RSVD_W = REG_W_P - NUM_FLAGS_P;

    logic                   rxc_q;
    logic                   txc_q;
    logic                   dre_q;
    logic                   txc_clr;
    logic [NUM_FLAGS_P-1:0] flag_vec;
    spi_role_e              role;
    logic                   wdata_unused;

    // Decode the write-one-to-clear request and the role
    always_comb begin
        txc_clr = flag_wr & flag_wdata[BIT_TXC];
        role    = mode_master ? ROLE_MASTER : ROLE_SLAVE;
    end

    // Flag-register bits other than transmit complete have no write effect
    assign wdata_unused = ^flag_wdata;

    spi_rxc_flag u_rxc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_enable (rx_enable),
        .char_rx   (char_rx),
        .data_rd   (data_rd),
        .rxc_q     (rxc_q)
    );

    spi_dre_flag u_dre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_load (tx_load),
        .data_wr (data_wr),
        .dre_q   (dre_q)
    );

    spi_txc_flag u_txc (
        .clk           (clk),
        .rst_n         (rst_n),
        .role          (role),
        .addr_match_en (addr_match_en),
        .shift_done    (shift_done),
        .ss_n          (ss_n),
        .addr_hit      (addr_hit),
        .buf_empty     (dre_q),
        .data_wr       (data_wr),
        .clr_req       (txc_clr),
        .txc_q         (txc_q)
    );

    // Assemble flags at their fixed bit positions
    always_comb begin
        flag_vec          = '0;
        flag_vec[BIT_DRE] = dre_q;
        flag_vec[BIT_TXC] = txc_q;
        flag_vec[BIT_RXC] = rxc_q;
    end

    assign flags_q = {{RSVD_W{1'b0}}, flag_vec};

    spi_irq_combine #(.N(NUM_FLAGS_P)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flag_vec),
        .en    (irq_en),
        .irq_q (irq)
    );
endmodule

// File: rtl/spi_irq_flags_chk.sv
// Module: property checker for spi_irq_flags, attached by bind. Watches
// ports only; holds no state of its own.
module spi_irq_flags_chk
    import spi_flag_pkg::*;
#(
    parameter int REG_W_P     = REG_W,
    parameter int NUM_FLAGS_P = NUM_FLAGS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode_master,
    input logic                   rx_enable,
    input logic                   char_rx,
    input logic                   tx_load,
    input logic                   data_rd,
    input logic                   data_wr,
    input logic                   flag_wr,
    input logic [NUM_FLAGS_P-1:0] irq_en,
    input logic [REG_W_P-1:0]     flags_q,
    input logic                   irq
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[REG_W_P-1:NUM_FLAGS_P] == '0);

    // R3
    rxc_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !char_rx) |=> !flags_q[BIT_RXC]);

    // R4
    rxc_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !flags_q[BIT_RXC]);

    // R9
    rxc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_rx && rx_enable) |=> flags_q[BIT_RXC]);

    // R6
    txc_data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && mode_master) |=> !flags_q[BIT_TXC]);

    // R8
    dre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> flags_q[BIT_DRE]);

    // R8
    dre_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_load) |=> !flags_q[BIT_DRE]);

    // R8
    dre_flagwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !tx_load && !data_wr) |=> $stable(flags_q[BIT_DRE]));

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_q[NUM_FLAGS_P-1:0] & irq_en)) |=> irq);

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags_q[NUM_FLAGS_P-1:0] & irq_en)) |=> !irq);
endmodule

bind spi_irq_flags spi_irq_flags_chk #(
    .REG_W_P     (REG_W_P),
    .NUM_FLAGS_P (NUM_FLAGS_P)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .rx_enable   (rx_enable),
    .char_rx     (char_rx),
    .tx_load     (tx_load),
    .data_rd     (data_rd),
    .data_wr     (data_wr),
    .flag_wr     (flag_wr),
    .irq_en      (irq_en),
    .flags_q     (flags_q),
    .irq         (irq)
);

// File: tb/sim_spi_irq_flags.sv
// Directed bench: one task per scenario, inputs driven after the falling
// edge, outputs sampled at the next falling edge.
module sim_spi_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_master = 1'b0;
    logic       addr_match_en = 1'b0;
    logic       rx_enable = 1'b1;
    logic       char_rx = 1'b0;
    logic       shift_done = 1'b0;
    logic       ss_n = 1'b1;
    logic       addr_hit = 1'b0;
    logic       tx_load = 1'b0;
    logic       data_rd = 1'b0;
    logic       data_wr = 1'b0;
    logic       flag_wr = 1'b0;
    logic [7:0] flag_wdata = 8'h00;
    logic [2:0] irq_en = 3'b000;
    logic [7:0] flags_q;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    spi_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .addr_match_en(addr_match_en), .rx_enable(rx_enable),
        .char_rx(char_rx), .shift_done(shift_done), .ss_n(ss_n),
        .addr_hit(addr_hit), .tx_load(tx_load), .data_rd(data_rd),
        .data_wr(data_wr), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .irq_en(irq_en), .flags_q(flags_q), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        char_rx = 0; shift_done = 0; addr_hit = 0; tx_load = 0;
        data_rd = 0; data_wr = 0; flag_wr = 0; flag_wdata = 8'h00;
    endtask

    task automatic t_reset();
        check("R1 flags after reset", flags_q, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_reserved();
        flag_wr = 1; flag_wdata = 8'hF8; step(); idle();
        check("R2 reserved write ignored", flags_q, 8'h00);
    endtask

    task automatic t_rxc();
        char_rx = 1; step(); idle();
        check("R3 rxc set", {7'b0, flags_q[2]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'hFD; step(); idle();
        check("R3 flag write leaves rxc", {7'b0, flags_q[2]}, 8'h01);
        data_rd = 1; step(); idle();
        check("R3 rxc read clear", {7'b0, flags_q[2]}, 8'h00);
        rx_enable = 0; char_rx = 1; step(); idle();
        check("R4 char ignored while disabled", {7'b0, flags_q[2]}, 8'h00);
        rx_enable = 1; char_rx = 1; step(); idle();
        rx_enable = 0; step();
        check("R4 disable clears rxc", {7'b0, flags_q[2]}, 8'h00);
        rx_enable = 1; step();
    endtask

    task automatic t_master();
        mode_master = 1;
        data_wr = 1; step(); idle();
        tx_load = 1; step(); idle();
        check("R8 dre after load", {7'b0, flags_q[0]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'hFF; step(); idle();
        check("R8 flag write leaves dre", {7'b0, flags_q[0]}, 8'h01);
        shift_done = 1; step(); idle();
        check("R5 master txc set", {7'b0, flags_q[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'h00; step(); idle();
        check("R6 write zero keeps txc", {7'b0, flags_q[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'h02; step(); idle();
        check("R6 write one clears txc", {7'b0, flags_q[1]}, 8'h00);
        data_wr = 1; step(); idle();
        check("R8 dre cleared by write", {7'b0, flags_q[0]}, 8'h00);
        shift_done = 1; step(); idle();
        check("R5 no txc with data waiting", {7'b0, flags_q[1]}, 8'h00);
        tx_load = 1; step(); idle();
        shift_done = 1; data_wr = 1; step(); idle();
        check("R5 no txc with same-cycle write", flags_q, 8'h00);
        tx_load = 1; step(); idle();
        shift_done = 1; step(); idle();
        check("R5 txc after refill drained", {7'b0, flags_q[1]}, 8'h01);
        data_wr = 1; step(); idle();
        check("R6 data write clears txc", flags_q, 8'h00);
    endtask

    task automatic t_slave();
        mode_master = 0; addr_match_en = 0;
        ss_n = 0; step(); step(); ss_n = 1; step();
        check("R7 slave txc on ss release", {7'b0, flags_q[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'h02; step(); idle();
        addr_match_en = 1;
        ss_n = 0; step(); step(); ss_n = 1; step();
        check("R7 no txc without address hit", {7'b0, flags_q[1]}, 8'h00);
        ss_n = 0; step(); addr_hit = 1; step(); idle(); ss_n = 1; step();
        check("R7 txc after address hit", {7'b0, flags_q[1]}, 8'h01);
        flag_wr = 1; flag_wdata = 8'h02; step(); idle();
        ss_n = 0; step(); step(); ss_n = 1; step();
        check("R7 hit forgotten after transaction", {7'b0, flags_q[1]}, 8'h00);
        addr_match_en = 0;
    endtask

    task automatic t_conflict();
        char_rx = 1; data_rd = 1; step(); idle();
        check("R9 rxc set beats read", {7'b0, flags_q[2]}, 8'h01);
        tx_load = 1; data_wr = 1; step(); idle();
        check("R9 dre load beats write", {7'b0, flags_q[0]}, 8'h01);
        ss_n = 0; step(); step();
        ss_n = 1; flag_wr = 1; flag_wdata = 8'h02; step(); idle();
        check("R9 txc set beats write-one", {7'b0, flags_q[1]}, 8'h01);
        data_rd = 1; data_wr = 1; step(); idle();
        check("R9 cleanup all clear", flags_q, 8'h00);
    endtask

    task automatic t_irq();
        tx_load = 1; step(); idle();
        step();
        check("R10 irq masked", {7'b0, irq}, 8'h00);
        data_wr = 1; step(); idle();
        irq_en = 3'b100;
        char_rx = 1; step(); idle();
        check("R10 irq lags flag", {7'b0, irq}, 8'h00);
        step();
        check("R10 irq raised", {7'b0, irq}, 8'h01);
        data_rd = 1; step(); idle();
        check("R10 irq held one cycle", {7'b0, irq}, 8'h01);
        step();
        check("R10 irq dropped", {7'b0, irq}, 8'h00);
        irq_en = 3'b000;
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1;
        t_reset();
        t_reserved();
        t_rxc();
        t_master();
        t_slave();
        t_conflict();
        t_irq();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule